// File: doc/BRIEF.md
# Accumulator Bit Manipulation Unit

This unit sits beside a pair of 36-bit main accumulators. It shifts, normalizes and does bit-field extraction and insertion on their contents. It also holds a bank of 36-bit alternate accumulators that can be swapped with, or loaded from, the main ones. Each accepted command writes at most one main and one alternate accumulator. The value written to the main accumulator, or to the alternate accumulator for a copy, comes back on a result stream. That stream also carries a normalization count and three condition flags, which conditional instructions consume.

Commands arrive on a valid/ready channel. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. Its accumulator updates happen on that edge, and its result appears on the result channel from that edge onward. The result channel is one register deep. `cmd_ready` is high whenever that register is empty or is being drained in the same cycle (`res_ready` high). While a result waits with `res_ready` low, no command is taken and the result stays exactly as it is. A command may read an accumulator that the command taken on the previous edge wrote, and it sees the new value.

Top module: `acc_bmu`

## Requirements
- R1: After reset every main and alternate accumulator holds zero, `res_valid` is low and all flags are low.
- R2: Opcode 7 (load) writes `cmd_data` into main accumulator `cmd_dst` and returns that value.
- R3: Opcode 0 (arithmetic shift) takes main accumulator `cmd_src` and writes it to `cmd_dst`, shifted by the signed 6-bit `cmd_shamt`. Positive values shift left with zero fill. Negative values shift right by the magnitude, filling with copies of bit 35. `flag_ovf` is high only for a left shift that loses a bit that differs from the result's sign.
- R4: Opcode 1 (logical shift) behaves like opcode 0, except that right shifts fill with zeros and `flag_ovf` is always low.
- R5: Opcode 2 (normalize) returns in `res_cnt` the left-shift count that makes bits 35 and 34 differ, and writes the shifted value to `cmd_dst`. A zero source gives count 0, value 0 and `flag_zero` high.
- R6: Opcode 3 (extract) writes to `cmd_dst` the field of width `cmd_fw`+1 (1 to 16) that starts at bit `cmd_off` of `cmd_src`. The field is right-justified and zero-filled. Field bits above bit 35 read as zero.
- R7: Opcode 4 (insert) replaces bits `cmd_off` upward, `cmd_fw`+1 bits wide (clipped at bit 35), of accumulator `cmd_dst` with the low bits of `cmd_src`. All other bits of `cmd_dst` are unchanged.
- R8: Opcode 5 (exchange) swaps main accumulator `cmd_dst` with alternate accumulator `cmd_alt` on a single edge. It returns the new main value.
- R9: Opcode 6 (copy out) writes main accumulator `cmd_src` into alternate `cmd_alt` and returns it. No main accumulator changes.
- R10: On every taken command, `flag_zero` is set when the returned value is zero and `flag_neg` equals its bit 35.
- R11: `cmd_ready` is low exactly when `res_valid` is high and `res_ready` is low. During such a stall no accumulator changes and the result outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_src | input | 1 | Source main accumulator index |
| cmd_dst | input | 1 | Destination main accumulator index |
| cmd_alt | input | 1 | Alternate accumulator index |
| cmd_shamt | input | 6 | Signed shift amount |
| cmd_fw | input | 4 | Field width minus one |
| cmd_off | input | 6 | Field offset (lowest bit) |
| cmd_data | input | 36 | Load value |
| res_valid | output | 1 | Result held |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 36 | Value written by the command |
| res_cnt | output | 6 | Normalization count |
| flag_zero | output | 1 | Result is zero |
| flag_neg | output | 1 | Result bit 35 |
| flag_ovf | output | 1 | Arithmetic left shift overflow |

## Verification
Two functions can meet on one edge: a read of an accumulator by the new command, and the write-back of the command before it. A stall on the result channel can also coincide with a fresh command being offered. Commands are driven back to back with random opcodes and one-bit indices, so a source often names the accumulator written one edge earlier. A reference model in the bench updates its own copy of both banks after each command and judges every returned value and flag against that copy. A directed stall holds `res_ready` low while a load is offered. The bench checks that `cmd_ready` drops and the held result stays unchanged, then releases the stall and confirms that the waiting load is taken.

// File: rtl/acc_bmu_pkg.sv
package acc_bmu_pkg;
  typedef enum logic [2:0] {
    OP_ASH   = 3'd0,
    OP_LSH   = 3'd1,
    OP_NORM  = 3'd2,
    OP_EXTR  = 3'd3,
    OP_INS   = 3'd4,
    OP_EXCH  = 3'd5,
    OP_TOALT = 3'd6,
    OP_LOAD  = 3'd7
  } bmu_op_e;

  typedef struct packed {
    logic zero;
    logic neg;
    logic ovf;
  } bmu_flags_t;
endpackage

// File: rtl/acc_bmu_shift.sv
module acc_bmu_shift #(
  parameter int W  = 36,
  parameter int SW = 6
) (
  input  logic [W-1:0]  src,
  input  logic [SW-1:0] amt,
  input  logic          arith,
  output logic [W-1:0]  res,
  output logic          ovf
);
  logic signed [W-1:0] s_src;
  logic signed [W-1:0] s_left;
  logic [SW-1:0]       lamt;
  logic [SW-1:0]       ramt;
  logic                go_right;

  assign s_src    = $signed(src);
  assign go_right = amt[SW-1];
  assign lamt     = {1'b0, amt[SW-2:0]};
  assign ramt     = SW'(0) - amt;
  assign s_left   = s_src <<< lamt;

  always_comb begin
    if (go_right) begin
      if (arith) res = W'(s_src >>> ramt);
      else       res = src >> ramt;
      ovf = 1'b0;
    end else begin
      res = W'(s_left);
      ovf = arith && ((s_left >>> lamt) != s_src);
    end
  end

  // logical right shifts never leave ones in the vacated top bits (R4)
  always_comb begin
    if (go_right && !arith)
      assert_lsr_fill_R4: assert ((res >> (W - int'(ramt))) == '0);
  end
endmodule

// File: rtl/acc_bmu_norm.sv
module acc_bmu_norm #(
  parameter int W  = 36,
  parameter int CW = 6
) (
  input  logic [W-1:0]  src,
  output logic [W-1:0]  res,
  output logic [CW-1:0] cnt
);
  logic run;

  always_comb begin
    cnt = '0;
    run = 1'b1;
    for (int i = W - 2; i >= 0; i--) begin
      if (run && (src[i] == src[W-1])) cnt = cnt + CW'(1);
      else                             run = 1'b0;
    end
    if (src == '0) cnt = '0;
    res = src << cnt;
  end

  always_comb begin
    if (src != '0)
      assert_norm_top_differ_R5: assert (res[W-1] != res[W-2]);
    else
      assert_norm_zero_cnt_R5: assert (cnt == '0 && res == '0);
  end
endmodule

// File: rtl/acc_bmu_field.sv
module acc_bmu_field #(
  parameter int W    = 36,
  parameter int FW_W = 4,
  parameter int OW   = 6
) (
  input  logic [W-1:0]    src,
  input  logic [W-1:0]    dst,
  input  logic [FW_W-1:0] fw_m1,
  input  logic [OW-1:0]   off,
  output logic [W-1:0]    ext,
  output logic [W-1:0]    ins
);
  logic [FW_W:0] width;
  logic [W-1:0]  fmask;
  logic [W-1:0]  pmask;

  assign width = {1'b0, fw_m1} + (FW_W+1)'(1);
  assign fmask = (W'(1) << width) - W'(1);
  assign pmask = fmask << off;
  assign ext   = (src >> off) & fmask;
  assign ins   = (dst & ~pmask) | ((src << off) & pmask);

  // a field inserted fully inside the word extracts back to the source bits (R6, R7)
  always_comb begin
    if ((int'(off) + int'(width)) <= W)
      assert_ins_ext_roundtrip_R7: assert (((ins >> off) & fmask) == (src & fmask));
  end
endmodule

// File: rtl/acc_bmu_bank.sv
module acc_bmu_bank #(
  parameter int W     = 36,
  parameter int NMAIN = 2,
  parameter int NALT  = 2,
  parameter int MI_W  = 1,
  parameter int AI_W  = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wm_en,
  input  logic [MI_W-1:0]           wm_idx,
  input  logic [W-1:0]              wm_dat,
  input  logic                      wa_en,
  input  logic [AI_W-1:0]           wa_idx,
  input  logic [W-1:0]              wa_dat,
  output logic [NMAIN-1:0][W-1:0]   main_q,
  output logic [NALT-1:0][W-1:0]    alt_q
);
  generate
    for (genvar g = 0; g < NMAIN; g++) begin : g_main
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  main_q[g] <= '0;
        else if (wm_en && (int'(wm_idx) == g))       main_q[g] <= wm_dat;
      end
    end
    for (genvar g = 0; g < NALT; g++) begin : g_alt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  alt_q[g] <= '0;
        else if (wa_en && (int'(wa_idx) == g))       alt_q[g] <= wa_dat;
      end
    end
  endgenerate
endmodule

// File: rtl/acc_bmu.sv
module acc_bmu #(
  parameter int ACC_W   = 36,
  parameter int NALT    = 2,
  parameter int FLD_MAX = 16,
  parameter int SH_W    = 6
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cmd_valid,
  output logic                                   cmd_ready,
  input  logic [2:0]                             cmd_op,
  input  logic                                   cmd_src,
  input  logic                                   cmd_dst,
  input  logic [((NALT > 1) ? $clog2(NALT) : 1)-1:0] cmd_alt,
  input  logic [SH_W-1:0]                        cmd_shamt,
  input  logic [$clog2(FLD_MAX)-1:0]             cmd_fw,
  input  logic [$clog2(ACC_W)-1:0]               cmd_off,
  input  logic [ACC_W-1:0]                       cmd_data,
  output logic                                   res_valid,
  input  logic                                   res_ready,
  output logic [ACC_W-1:0]                       res_data,
  output logic [$clog2(ACC_W)-1:0]               res_cnt,
  output logic                                   flag_zero,
  output logic                                   flag_neg,
  output logic                                   flag_ovf
);
  import acc_bmu_pkg::*;

  localparam int NMAIN = 2;
  localparam int AI_W  = (NALT > 1) ? $clog2(NALT) : 1;
  localparam int FW_W  = $clog2(FLD_MAX);
  localparam int CW    = $clog2(ACC_W);

  logic [NMAIN-1:0][ACC_W-1:0] main_q;
  logic [NALT-1:0][ACC_W-1:0]  alt_q;
  logic [ACC_W-1:0] src_v, dst_v, alt_v;
  logic [ACC_W-1:0] sh_res, nm_res, ext_res, ins_res;
  logic [CW-1:0]    nm_cnt;
  logic             sh_ovf, accept;
  bmu_op_e          op;

  logic             wm_en, wa_en;
  logic [ACC_W-1:0] nxt_res, wa_dat;
  logic [CW-1:0]    nxt_cnt;
  bmu_flags_t       nxt_flags;

  assign op        = bmu_op_e'(cmd_op);
  assign cmd_ready = !res_valid || res_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign src_v     = main_q[cmd_src];
  assign dst_v     = main_q[cmd_dst];
  assign alt_v     = alt_q[cmd_alt];

  acc_bmu_shift #(.W(ACC_W), .SW(SH_W)) u_shift (
    .src(src_v), .amt(cmd_shamt), .arith(op == OP_ASH), .res(sh_res), .ovf(sh_ovf)
  );

  acc_bmu_norm #(.W(ACC_W), .CW(CW)) u_norm (
    .src(src_v), .res(nm_res), .cnt(nm_cnt)
  );

  acc_bmu_field #(.W(ACC_W), .FW_W(FW_W), .OW(CW)) u_field (
    .src(src_v), .dst(dst_v), .fw_m1(cmd_fw), .off(cmd_off), .ext(ext_res), .ins(ins_res)
  );

  always_comb begin
    wm_en   = 1'b0;
    wa_en   = 1'b0;
    wa_dat  = '0;
    nxt_res = '0;
    nxt_cnt = '0;
    nxt_flags.ovf = 1'b0;
    unique case (op)
      OP_ASH:   begin nxt_res = sh_res; nxt_flags.ovf = sh_ovf; wm_en = 1'b1; end
      OP_LSH:   begin nxt_res = sh_res; wm_en = 1'b1; end
      OP_NORM:  begin nxt_res = nm_res; nxt_cnt = nm_cnt; wm_en = 1'b1; end
      OP_EXTR:  begin nxt_res = ext_res; wm_en = 1'b1; end
      OP_INS:   begin nxt_res = ins_res; wm_en = 1'b1; end
      OP_EXCH:  begin nxt_res = alt_v; wm_en = 1'b1; wa_en = 1'b1; wa_dat = dst_v; end
      OP_TOALT: begin nxt_res = src_v; wa_en = 1'b1; wa_dat = src_v; end
      OP_LOAD:  begin nxt_res = cmd_data; wm_en = 1'b1; end
      default:  begin nxt_res = '0; end
    endcase
    nxt_flags.zero = (nxt_res == '0);
    nxt_flags.neg  = nxt_res[ACC_W-1];
  end

  acc_bmu_bank #(.W(ACC_W), .NMAIN(NMAIN), .NALT(NALT), .MI_W(1), .AI_W(AI_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wm_en(wm_en && accept), .wm_idx(cmd_dst), .wm_dat(nxt_res),
    .wa_en(wa_en && accept), .wa_idx(cmd_alt), .wa_dat(wa_dat),
    .main_q(main_q), .alt_q(alt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_cnt   <= '0;
      flag_zero <= 1'b0;
      flag_neg  <= 1'b0;
      flag_ovf  <= 1'b0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_data  <= nxt_res;
      res_cnt   <= nxt_cnt;
      flag_zero <= nxt_flags.zero;
      flag_neg  <= nxt_flags.neg;
      flag_ovf  <= nxt_flags.ovf;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_cnt)
                                   && $stable(main_q) && $stable(alt_q)));

  assert_exch_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_EXCH) |=>
      (main_q[$past(cmd_dst)] == $past(alt_q[cmd_alt])) &&
      (alt_q[$past(cmd_alt)] == $past(main_q[cmd_dst])));

  assert_toalt_main_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op == OP_TOALT) |=> $stable(main_q));

  assert_flag_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flag_zero == (res_data == '0)));

  assert_flag_neg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (flag_neg == res_data[ACC_W-1]));

  assert_cnt_only_norm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op != OP_NORM) |=> (res_cnt == '0));
endmodule

// File: tb/acc_bmu_tb.sv
module acc_bmu_tb_top;
  localparam int W = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic          cmd_src = 1'b0, cmd_dst = 1'b0;
  logic [0:0]    cmd_alt = '0;
  logic [5:0]    cmd_shamt = '0;
  logic [3:0]    cmd_fw = '0;
  logic [5:0]    cmd_off = '0;
  logic [W-1:0]  cmd_data = '0;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic [W-1:0]  res_data;
  logic [5:0]    res_cnt;
  logic          flag_zero, flag_neg, flag_ovf;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] m_main [2];
  logic [W-1:0] m_alt  [2];

  always #5 clk = ~clk;

  acc_bmu dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_alt(cmd_alt),
    .cmd_shamt(cmd_shamt), .cmd_fw(cmd_fw), .cmd_off(cmd_off), .cmd_data(cmd_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_cnt(res_cnt),
    .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_ovf(flag_ovf)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W:0] m_shift(input logic arith, input logic [W-1:0] v, input logic [5:0] amt);
    logic [W-1:0] r;
    logic ov;
    r = v;
    ov = 1'b0;
    if (amt[5]) begin
      for (int k = 0; k < (64 - int'(amt)); k++) r = {(arith ? r[W-1] : 1'b0), r[W-1:1]};
    end else begin
      for (int k = 0; k < int'(amt); k++) r = {r[W-2:0], 1'b0};
      if (arith)
        for (int i = W - 1; i >= W - 1 - int'(amt); i--) if (v[i] != v[W-1]) ov = 1'b1;
    end
    return {ov, r};
  endfunction

  function automatic logic [W+5:0] m_norm(input logic [W-1:0] v);
    logic [W-1:0] r;
    int c;
    r = v;
    c = 0;
    if (v != '0)
      while (r[W-1] == r[W-2]) begin r = {r[W-2:0], 1'b0}; c++; end
    return {6'(c), r};
  endfunction

  function automatic logic [W-1:0] m_ext(input logic [W-1:0] v, input int w, input int off);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < w; i++) if (off + i < W) r[i] = v[off + i];
    return r;
  endfunction

  function automatic logic [W-1:0] m_ins(input logic [W-1:0] d, input logic [W-1:0] s, input int w, input int off);
    logic [W-1:0] r;
    r = d;
    for (int i = 0; i < w; i++) if (off + i < W) r[off + i] = s[i];
    return r;
  endfunction

  task automatic do_cmd(input string req, input logic [2:0] op, input logic s, input logic d,
                        input logic a, input logic [5:0] sh, input logic [3:0] fw,
                        input logic [5:0] off, input logic [W-1:0] data);
    logic [W-1:0] e_res;
    logic [5:0]   e_cnt;
    logic         e_ovf;
    logic [W:0]   shr;
    logic [W+5:0] nr;
    e_cnt = '0;
    e_ovf = 1'b0;
    e_res = '0;
    case (op)
      3'd0, 3'd1: begin shr = m_shift(op == 3'd0, m_main[s], sh); e_res = shr[W-1:0]; e_ovf = shr[W]; m_main[d] = e_res; end
      3'd2: begin nr = m_norm(m_main[s]); e_res = nr[W-1:0]; e_cnt = nr[W+5:W]; m_main[d] = e_res; end
      3'd3: begin e_res = m_ext(m_main[s], int'(fw) + 1, int'(off)); m_main[d] = e_res; end
      3'd4: begin e_res = m_ins(m_main[d], m_main[s], int'(fw) + 1, int'(off)); m_main[d] = e_res; end
      3'd5: begin e_res = m_alt[a]; m_alt[a] = m_main[d]; m_main[d] = e_res; end
      3'd6: begin e_res = m_main[s]; m_alt[a] = e_res; end
      default: begin e_res = data; m_main[d] = e_res; end
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_src = s; cmd_dst = d; cmd_alt = a;
    cmd_shamt = sh; cmd_fw = fw; cmd_off = off; cmd_data = data;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1;
    chk(req, "res_data", res_data, e_res);
    chk(req, "res_cnt", W'(res_cnt), W'(e_cnt));
    chk("R10", "flag_zero", W'(flag_zero), W'(e_res == '0));
    chk("R10", "flag_neg", W'(flag_neg), W'(e_res[W-1]));
    chk(req, "flag_ovf", W'(flag_ovf), W'(e_ovf));
  endtask

  task automatic peek_main(input string req, input logic k);
    do_cmd(req, 3'd1, k, k, 1'b0, 6'd0, 4'd0, 6'd0, '0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2; i++) begin m_main[i] = '0; m_alt[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "res_valid after reset", W'(res_valid), '0);
    chk("R1", "flags after reset", W'({flag_zero, flag_neg, flag_ovf}), '0);
    @(negedge clk) rst_n = 1'b1;
    peek_main("R1", 1'b0);
    peek_main("R1", 1'b1);
    do_cmd("R1", 3'd5, 1'b0, 1'b0, 1'b1, 6'd0, 4'd0, 6'd0, '0);

    do_cmd("R2", 3'd7, 1'b0, 1'b0, 1'b0, 6'd0, 4'd0, 6'd0, 36'h8_0000_0001);
    do_cmd("R2", 3'd7, 1'b0, 1'b1, 1'b0, 6'd0, 4'd0, 6'd0, 36'h0_1234_5678);
    do_cmd("R3", 3'd0, 1'b0, 1'b1, 1'b0, 6'h20, 4'd0, 6'd0, '0);
    do_cmd("R7", 3'd7, 1'b0, 1'b0, 1'b0, 6'd0, 4'd0, 6'd0, 36'h8_0000_0001);
    do_cmd("R4", 3'd1, 1'b0, 1'b1, 1'b0, 6'h3F, 4'd0, 6'd0, '0);
    do_cmd("R3", 3'd0, 1'b1, 1'b1, 1'b0, 6'd31, 4'd0, 6'd0, '0);
    do_cmd("R3", 3'd7, 1'b0, 1'b0, 1'b0, 6'd0, 4'd0, 6'd0, 36'h0_0000_0003);
    do_cmd("R3", 3'd0, 1'b0, 1'b1, 1'b0, 6'd33 - 6'd1, 4'd0, 6'd0, '0);
    do_cmd("R5", 3'd7, 1'b0, 1'b0, 1'b0, 6'd0, 4'd0, 6'd0, '0);
    do_cmd("R5", 3'd2, 1'b0, 1'b1, 1'b0, 6'd0, 4'd0, 6'd0, '0);
    do_cmd("R5", 3'd7, 1'b0, 1'b0, 1'b0, 6'd0, 4'd0, 6'd0, '1);
    do_cmd("R5", 3'd2, 1'b0, 1'b1, 1'b0, 6'd0, 4'd0, 6'd0, '0);
    do_cmd("R5", 3'd7, 1'b0, 1'b0, 1'b0, 6'd0, 4'd0, 6'd0, 36'd1);
    do_cmd("R5", 3'd2, 1'b0, 1'b1, 1'b0, 6'd0, 4'd0, 6'd0, '0);
    do_cmd("R6", 3'd7, 1'b0, 1'b0, 1'b0, 6'd0, 4'd0, 6'd0, 36'hA_5A5A_5A5A);
    do_cmd("R6", 3'd3, 1'b0, 1'b1, 1'b0, 6'd0, 4'd15, 6'd30, '0);
    do_cmd("R6", 3'd3, 1'b0, 1'b1, 1'b0, 6'd0, 4'd0, 6'd35, '0);
    do_cmd("R7", 3'd7, 1'b0, 1'b1, 1'b0, 6'd0, 4'd0, 6'd0, 36'h0_0000_0000);
    do_cmd("R7", 3'd4, 1'b0, 1'b1, 1'b0, 6'd0, 4'd15, 6'd28, '0);
    do_cmd("R7", 3'd4, 1'b0, 1'b1, 1'b0, 6'd0, 4'd3, 6'd4, '0);
    do_cmd("R8", 3'd5, 1'b0, 1'b1, 1'b0, 6'd0, 4'd0, 6'd0, '0);
    do_cmd("R8", 3'd5, 1'b0, 1'b1, 1'b0, 6'd0, 4'd0, 6'd0, '0);
    do_cmd("R9", 3'd6, 1'b0, 1'b0, 1'b1, 6'd0, 4'd0, 6'd0, '0);
    peek_main("R9", 1'b0);
    peek_main("R9", 1'b1);
    do_cmd("R9", 3'd5, 1'b0, 1'b1, 1'b1, 6'd0, 4'd0, 6'd0, '0);

    // R11: stall with a load waiting
    do_cmd("R11", 3'd7, 1'b0, 1'b0, 1'b0, 6'd0, 4'd0, 6'd0, 36'h1_1111_1111);
    held = res_data;
    @(negedge clk);
    res_ready = 1'b0;
    cmd_op = 3'd7; cmd_dst = 1'b0; cmd_data = 36'h2_2222_2222;
    #1;
    chk("R11", "cmd_ready during stall", W'(cmd_ready), '0);
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "held result", res_data, held);
    chk("R11", "valid held", W'(res_valid), W'(1));
    @(negedge clk);
    res_ready = 1'b1;
    #1;
    chk("R11", "cmd_ready after release", W'(cmd_ready), W'(1));
    @(posedge clk);
    #1;
    chk("R11", "waiting load taken", res_data, 36'h2_2222_2222);
    m_main[0] = 36'h2_2222_2222;

    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      logic [W-1:0] dv;
      op = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 5))
        0: dv = '0;
        1: dv = '1;
        default: dv = {4'($urandom()), 32'($urandom())};
      endcase
      do_cmd(op == 3'd0 ? "R3" : op == 3'd1 ? "R4" : op == 3'd2 ? "R5" : op == 3'd3 ? "R6" :
             op == 3'd4 ? "R7" : op == 3'd5 ? "R8" : op == 3'd6 ? "R9" : "R2",
             op, 1'($urandom()), 1'($urandom()), 1'($urandom()), 6'($urandom()),
             4'($urandom()), 6'($urandom_range(0, 39)), dv);
    end
    @(negedge clk) cmd_valid = 1'b0;
    report();
  end
endmodule